// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers interrupt requests from three sources, a disk controller, a coprocessor and the video vertical blank, and drives one interrupt line to a host CPU. Each source owns one bit of an 8-bit status register. The CPU interrupt line is high while any status bit is set.

When the CPU acknowledges, it raises `ack_req` for one cycle. One cycle later the block answers with `ack_done` and an 8-bit vector for the most urgent pending source. The disk controller ranks first, the coprocessor second and vertical blank last. In the same step the block clears the bit of the source it granted, but only if that source is edge-type. The disk request is a level: its bit tracks its input and is never cleared by an acknowledge. An acknowledge that finds no source pending returns vector 0 and flags an error.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the status register is 0, `cpu_irq` is low, and `ack_done`, `ack_vector` and `ack_error` are 0.
- R2: Status bit 7 (disk) equals the value `disk_req` had at the previous clock edge. It sets and clears with the input.
- R3: A cycle with `copro_strobe` high sets status bit 4 (coprocessor) at that clock edge.
- R4: Status bit 5 (vertical blank) is set only on a clock edge where `vblank` is high and was low at the previous edge. Holding `vblank` high does not set the bit again after an acknowledge has cleared it.
- R5: `cpu_irq` is high exactly when some status bit is set.
- R6: Each cycle with `ack_req` high produces `ack_done` high in the following cycle only. The vector and error answer appear in that same following cycle.
- R7: The vector returned is 11 when bit 7 is pending. Otherwise it is 12 when bit 4 is pending, otherwise 13 when bit 5 is pending.
- R8: An acknowledge clears bit 4 or bit 5 only when that source is the one granted. Bit 7 and the sources not granted are left as they were.
- R9: An acknowledge with bits 4, 5 and 7 all clear returns vector 0 with `ack_error` high. In every other case `ack_error` is low.
- R10: If a source's set event (strobe or rising edge) falls in the same cycle as the acknowledge that clears it, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disk_req | input | 1 | Level request from the disk controller |
| copro_strobe | input | 1 | One-cycle write strobe from the coprocessor |
| vblank | input | 1 | Vertical blank level; its rising edge requests |
| ack_req | input | 1 | CPU acknowledge request, one cycle per acknowledge |
| ack_done | output | 1 | Acknowledge answered, one cycle after `ack_req` |
| ack_vector | output | 8 | Vector of the granted source, or 0 |
| ack_error | output | 1 | Acknowledge found no source pending |
| cpu_irq | output | 1 | Interrupt line to the CPU |
| status | output | 8 | Pending bits: 7 disk, 5 vertical blank, 4 coprocessor |

## Verification
The assertions check these rules on every cycle: the disk bit tracks its input, a vertical-blank bit can only rise after a high `vblank`, every acknowledge is answered exactly one cycle later, and the interrupt line agrees with the status register. The assertions also check that a pending disk source always wins the grant and that an acknowledge with nothing pending reports an error. The bench covers the cases that need a known history. It walks all eight combinations of pending sources and compares the vector and the status left after the acknowledge with values it computes itself. It also checks that a held blank level does not fire again, and that a set arriving together with its clear wins.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int VEC_W      = 8,
  parameter int STAT_W     = 8,
  parameter int VEC_DISK   = 11,
  parameter int VEC_COPRO  = 12,
  parameter int VEC_VBLANK = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disk_req,
  input  logic              copro_strobe,
  input  logic              vblank,
  input  logic              ack_req,
  output logic              ack_done,
  output logic [VEC_W-1:0]  ack_vector,
  output logic              ack_error,
  output logic              cpu_irq,
  output logic [STAT_W-1:0] status
);
  localparam int BIT_COPRO  = 4;
  localparam int BIT_VBLANK = 5;
  localparam int BIT_DISK   = 7;

  logic [STAT_W-1:0] stat_q;
  logic              vblank_q;

  wire vblank_rise = vblank & ~vblank_q;
  wire grant_disk  = stat_q[BIT_DISK];
  wire grant_copro = ~grant_disk & stat_q[BIT_COPRO];
  wire grant_vbl   = ~grant_disk & ~stat_q[BIT_COPRO] & stat_q[BIT_VBLANK];
  wire grant_none  = ~(grant_disk | grant_copro | grant_vbl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q     <= '0;
      vblank_q   <= 1'b0;
      ack_done   <= 1'b0;
      ack_vector <= '0;
      ack_error  <= 1'b0;
    end else begin
      vblank_q         <= vblank;
      stat_q[BIT_DISK] <= disk_req;

      if (copro_strobe)               stat_q[BIT_COPRO] <= 1'b1;
      else if (ack_req && grant_copro) stat_q[BIT_COPRO] <= 1'b0;

      if (vblank_rise)              stat_q[BIT_VBLANK] <= 1'b1;
      else if (ack_req && grant_vbl) stat_q[BIT_VBLANK] <= 1'b0;

      ack_done <= ack_req;
      if (ack_req) begin
        ack_error <= grant_none;
        if (grant_disk)       ack_vector <= VEC_W'(VEC_DISK);
        else if (grant_copro) ack_vector <= VEC_W'(VEC_COPRO);
        else if (grant_vbl)   ack_vector <= VEC_W'(VEC_VBLANK);
        else                  ack_vector <= '0;
      end
    end
  end

  assign status  = stat_q;
  assign cpu_irq = |stat_q;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int VEC_W  = 8,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disk_req,
  input logic              copro_strobe,
  input logic              vblank,
  input logic              ack_req,
  input logic              ack_done,
  input logic [VEC_W-1:0]  ack_vector,
  input logic              ack_error,
  input logic              cpu_irq,
  input logic [STAT_W-1:0] status
);
  AST_DISK_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> status[7] == $past(disk_req)); // R2

  AST_COPRO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    copro_strobe |=> status[4]); // R3

  AST_VBL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> $past(vblank)); // R4

  AST_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (status != '0)); // R5

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_done); // R6

  AST_ACK_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_done); // R6

  AST_DISK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && status[7] |=> ack_vector == VEC_W'(11) && !ack_error); // R7

  AST_DISK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && status[7] && disk_req |=> status[7]); // R8

  AST_EMPTY_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && !status[7] && !status[5] && !status[4] |=> ack_error && ack_vector == '0); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && copro_strobe |=> status[4]); // R10
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.VEC_W(VEC_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disk_req(disk_req), .copro_strobe(copro_strobe),
  .vblank(vblank), .ack_req(ack_req), .ack_done(ack_done), .ack_vector(ack_vector),
  .ack_error(ack_error), .cpu_irq(cpu_irq), .status(status)
);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disk_req = 1'b0, copro_strobe = 1'b0, vblank = 1'b0, ack_req = 1'b0;
  logic ack_done, ack_error, cpu_irq;
  logic [7:0] ack_vector, status;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .disk_req(disk_req), .copro_strobe(copro_strobe),
    .vblank(vblank), .ack_req(ack_req), .ack_done(ack_done), .ack_vector(ack_vector),
    .ack_error(ack_error), .cpu_irq(cpu_irq), .status(status)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; disk_req = 0; copro_strobe = 0; vblank = 0; ack_req = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_ack();
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  function automatic logic [7:0] stat_of(input logic d, input logic c, input logic v);
    return {d, 1'b0, v, c, 4'b0};
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    check("R1", "status", int'(status), 0);
    check("R1", "cpu_irq", int'(cpu_irq), 0);
    check("R1", "ack outputs", int'({ack_done, ack_error, ack_vector}), 0);

    for (int k = 0; k < 8; k++) begin
      logic d, c, v;
      int exp_vec;
      logic [7:0] exp_stat;
      d = k[2]; c = k[1]; v = k[0];
      do_reset();
      disk_req = d; copro_strobe = c; vblank = v;
      @(negedge clk);
      copro_strobe = 1'b0;
      exp_stat = stat_of(d, c, v);
      check("R2_R3_R4", "status before ack", int'(status), int'(exp_stat));
      check("R5", "cpu_irq before ack", int'(cpu_irq), int'(exp_stat != 0));
      exp_vec = d ? 11 : c ? 12 : v ? 13 : 0;
      do_ack();
      check("R6", "ack_done", int'(ack_done), 1);
      check("R7", "vector", int'(ack_vector), exp_vec);
      check("R9", "error", int'(ack_error), int'(exp_vec == 0));
      exp_stat = stat_of(d, c & d, v & (d | c));
      check("R8", "status after ack", int'(status), int'(exp_stat));
      check("R5", "cpu_irq after ack", int'(cpu_irq), int'(exp_stat != 0));
      @(negedge clk);
      check("R6", "ack_done falls", int'(ack_done), 0);
      check("R4", "held vblank no retrigger", int'(status[5]), int'(v & (d | c)));
      disk_req = 1'b0;
      @(negedge clk);
      check("R2", "disk bit clears", int'(status[7]), 0);
    end

    do_reset();
    copro_strobe = 1'b1;
    @(negedge clk);
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0; copro_strobe = 1'b0;
    check("R10", "copro set beats clear", int'(status[4]), 1);
    check("R7", "vector for copro", int'(ack_vector), 12);
    do_ack();
    check("R8", "copro cleared", int'(status[4]), 0);

    do_reset();
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
    @(negedge clk);
    vblank = 1'b1; ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
    check("R10", "vblank edge beats clear", int'(status[5]), 1);
    check("R7", "vector for vblank", int'(ack_vector), 13);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule